// File: doc/BRIEF.md
# Event Data Block Formatter

This block assembles the 32-bit event stream of a 16-input strip readout module. An event opens when a descriptor is accepted on the event port. The descriptor carries the trigger type, the data type, the clock-to-trigger phase, the module number and the system event number. The block then walks the inputs in ascending order. For each input it takes one common-mode record from the correction stream. If the configuration enables per-input headers, it emits an input header. It then forwards that input's hit words from the hit stream, which marks the last hit of each input. A record flagged empty means the input has no hits. The event closes with a trailer that holds a CRC16 of every word emitted before it.

Each input also has a free-running 7-bit event counter, which advances on every chip header seen at that input. When an input's record is taken, its count is compared with the low seven bits of the system event number. A mismatch sets that input's error bit, and the error bits are reported in the trailer. Four sideband flags travel with every output word: main header, trailer, data, and second-half.

All three input streams and the output use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. A source that raises valid must hold it, and the payload, stable until the transfer. Valid never waits on ready. Holding `out_ready` low is the downstream busy: while it is low, the output word and its flags stay frozen and nothing is consumed.

Top module: `evt_block_fmt`

## Requirements
- R1: The main header is the first word of each event. Its layout is: bit 31 = 0, bits 30-27 trigger type, bits 25-23 data type, bits 20-16 clock-to-trigger phase, bits 13-9 module number, bits 7-0 system event number. All other bits are 0.
- R2: The input header layout is: bit 31 = 1, bits 29-23 that input's event count, bits 19-16 input number, bits 15-9 second common-mode correction, bits 8-0 first common-mode correction. All other bits are 0.
- R3: The hit word layout is: bits 31-23 = 0, bits 22-20 time block (1 to 6), bits 19-16 input number, bits 15-9 strip position, bits 8-0 pulse height.
- R4: Inputs are visited in order from 0 to 15. Exactly one correction record is taken per input. An input whose record is flagged empty contributes no hit words.
- R5: When `cfg_ihdr_en` is low at event acceptance, no input headers are emitted for that event. Correction records are still consumed, and hits are still emitted.
- R6: The trailer is the last word of each event. Its bits 31-16 hold a CRC16 with polynomial 0x1021 and seed 0xFFFF. Each word is fed MSB first, over every word of the event before the trailer.
- R7: Trailer bit i (bits 15-0) is 1 when input i's event count differed from the low seven bits of the system event number at the time its record was taken. The error bits restart at 0 for every event.
- R8: Flag rules:
  - `out_hdr` is high on the main header only.
  - `out_trl` is high on the trailer only.
  - `out_den` is high on input headers and hit words.
  - `out_half` is high on input headers and hits of inputs 8 to 15.
- R9: While `out_valid` is high and `out_ready` is low, the output word and flags hold their values. No word is lost or repeated.
- R10: Each input's event counter is 7 bits wide, starts at 0 after reset, and increments by one per `chip_hdr_seen` pulse, wrapping from 127 to 0.
- R11: After reset, `out_valid` is low and `evt_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ihdr_en | input | 1 | Emit per-input headers |
| chip_hdr_seen | input | 16 | One pulse per chip header seen at each input |
| evt_valid | input | 1 | Event descriptor valid |
| evt_ready | output | 1 | Formatter idle, accepts descriptor |
| evt_trig_type | input | 4 | Trigger type |
| evt_data_type | input | 3 | Data type |
| evt_clk_phase | input | 5 | Clock-to-trigger phase |
| evt_module | input | 5 | Module number |
| evt_number | input | 8 | System event number |
| cm_valid | input | 1 | Correction record valid |
| cm_ready | output | 1 | Correction record taken |
| cm_corr1 | input | 9 | First common-mode correction |
| cm_corr2 | input | 7 | Second common-mode correction |
| cm_empty | input | 1 | Input has no hits |
| hit_valid | input | 1 | Hit valid |
| hit_ready | output | 1 | Hit taken |
| hit_tblk | input | 3 | Time block |
| hit_strip | input | 7 | Strip position |
| hit_height | input | 9 | Pulse height |
| hit_last | input | 1 | Last hit of current input |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready (low = busy) |
| out_data | output | 32 | Output word |
| out_hdr | output | 1 | Main header flag |
| out_trl | output | 1 | Trailer flag |
| out_den | output | 1 | Input data flag |
| out_half | output | 1 | Second-half input flag |

## Verification
The output hold checks assume the correction and hit sources obey the handshake. Once they raise valid, they must keep the payload steady until it is taken, because those words pass straight through to the output. The assertions also assume `chip_hdr_seen` pulses arrive only while the formatter is idle. The stimulus drives its sources this way: each payload changes only one cycle after its handshake edge, and chip header pulses are issued only between events. Downstream readiness follows a pseudo-random pattern, so stalls land on every word type.

// File: rtl/evfmt_pkg.sv
package evfmt_pkg;
  localparam int CNT_W = 7;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    S_IDLE, S_MHDR, S_IHDR, S_HITS, S_TRL
  } fmt_state_e;

  function automatic logic [15:0] crc_step32(input logic [15:0] c_in,
                                             input logic [31:0] w);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int k = 31; k >= 0; k--) begin
      fb = c[15] ^ w[k];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/fmt_crc16.sv
module fmt_crc16
  import evfmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic [31:0] word,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (upd)    crc <= crc_step32(crc, word);
  end

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (rst)
    init |=> crc == CRC_SEED); // R6
endmodule

// File: rtl/fmt_evtcnt.sv
module fmt_evtcnt
  import evfmt_pkg::*;
#(
  parameter int N_IN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  seen,
  output logic [CNT_W-1:0] cnt [N_IN]
);
  for (genvar g = 0; g < N_IN; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)          cnt[g] <= '0;
      else if (seen[g]) cnt[g] <= cnt[g] + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      seen[g] |=> cnt[g] == CNT_W'($past(cnt[g]) + 1'b1)); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !seen[g] |=> $stable(cnt[g])); // R10
  end
endmodule

// File: rtl/fmt_seq.sv
module fmt_seq
  import evfmt_pkg::*;
#(
  parameter int N_IN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_ihdr_en,
  input  logic [CNT_W-1:0] cnt [N_IN],
  input  logic [15:0]      crc,
  output logic             crc_init,
  output logic             crc_upd,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [3:0]       evt_trig_type,
  input  logic [2:0]       evt_data_type,
  input  logic [4:0]       evt_clk_phase,
  input  logic [4:0]       evt_module,
  input  logic [7:0]       evt_number,
  input  logic             cm_valid,
  output logic             cm_ready,
  input  logic [8:0]       cm_corr1,
  input  logic [6:0]       cm_corr2,
  input  logic             cm_empty,
  input  logic             hit_valid,
  output logic             hit_ready,
  input  logic [2:0]       hit_tblk,
  input  logic [6:0]       hit_strip,
  input  logic [8:0]       hit_height,
  input  logic             hit_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_hdr,
  output logic             out_trl,
  output logic             out_den,
  output logic             out_half
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_IN - 1);
  localparam logic [IW-1:0] HALF_IDX = IW'(N_IN / 2);

  fmt_state_e       state;
  logic [IW-1:0]    cur;
  logic             en_q;
  logic [3:0]       tt_q;
  logic [2:0]       dt_q;
  logic [4:0]       ph_q;
  logic [4:0]       md_q;
  logic [7:0]       ev_q;
  logic [N_IN-1:0]  err;
  logic [15:0]      err_field;
  logic [CNT_W-1:0] cur_cnt;
  logic [3:0]       inum;
  logic             fire;

  assign cur_cnt = cnt[cur];
  assign inum    = 4'(cur);

  always_comb begin
    err_field = '0;
    err_field[N_IN-1:0] = err;
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_hdr   = 1'b0;
    out_trl   = 1'b0;
    out_den   = 1'b0;
    out_half  = 1'b0;
    evt_ready = 1'b0;
    cm_ready  = 1'b0;
    hit_ready = 1'b0;
    case (state)
      S_IDLE: evt_ready = 1'b1;
      S_MHDR: begin
        out_valid = 1'b1;
        out_hdr   = 1'b1;
        out_data  = {1'b0, tt_q, 1'b0, dt_q, 2'b00, ph_q, 2'b00, md_q, 1'b0, ev_q};
      end
      S_IHDR: begin
        if (en_q) begin
          out_valid = cm_valid;
          out_den   = 1'b1;
          out_half  = cur >= HALF_IDX;
          out_data  = {1'b1, 1'b0, cur_cnt, 3'b000, inum, cm_corr2, cm_corr1};
          cm_ready  = out_ready;
        end else begin
          cm_ready  = 1'b1;
        end
      end
      S_HITS: begin
        out_valid = hit_valid;
        out_den   = 1'b1;
        out_half  = cur >= HALF_IDX;
        out_data  = {9'd0, hit_tblk, inum, hit_strip, hit_height};
        hit_ready = out_ready;
      end
      S_TRL: begin
        out_valid = 1'b1;
        out_trl   = 1'b1;
        out_data  = {crc, err_field};
      end
      default: ;
    endcase
  end

  assign fire     = out_valid && out_ready;
  assign crc_init = evt_valid && evt_ready;
  assign crc_upd  = fire && (state != S_TRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cur   <= '0;
      en_q  <= 1'b0;
      err   <= '0;
      tt_q  <= '0;
      dt_q  <= '0;
      ph_q  <= '0;
      md_q  <= '0;
      ev_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (evt_valid) begin
          tt_q  <= evt_trig_type;
          dt_q  <= evt_data_type;
          ph_q  <= evt_clk_phase;
          md_q  <= evt_module;
          ev_q  <= evt_number;
          en_q  <= cfg_ihdr_en;
          err   <= '0;
          cur   <= '0;
          state <= S_MHDR;
        end
        S_MHDR: if (out_ready) state <= S_IHDR;
        S_IHDR: if (cm_valid && cm_ready) begin
          err[cur] <= cur_cnt != ev_q[CNT_W-1:0];
          if (!cm_empty)            state <= S_HITS;
          else if (cur == LAST_IDX) state <= S_TRL;
          else                      cur   <= cur + 1'b1;
        end
        S_HITS: if (hit_valid && hit_ready && hit_last) begin
          if (cur == LAST_IDX) state <= S_TRL;
          else begin
            cur   <= cur + 1'b1;
            state <= S_IHDR;
          end
        end
        S_TRL: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_INPUT_ORDER: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur) |-> (cur == IW'($past(cur) + 1'b1)) || (cur == '0)); // R4
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_hdr, out_trl, out_den})); // R8
  AST_TRL_CLOSES: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_trl |=> evt_ready); // R6
endmodule

// File: rtl/evt_block_fmt.sv
module evt_block_fmt
  import evfmt_pkg::*;
#(
  parameter int N_IN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_ihdr_en,
  input  logic [N_IN-1:0] chip_hdr_seen,
  input  logic            evt_valid,
  output logic            evt_ready,
  input  logic [3:0]      evt_trig_type,
  input  logic [2:0]      evt_data_type,
  input  logic [4:0]      evt_clk_phase,
  input  logic [4:0]      evt_module,
  input  logic [7:0]      evt_number,
  input  logic            cm_valid,
  output logic            cm_ready,
  input  logic [8:0]      cm_corr1,
  input  logic [6:0]      cm_corr2,
  input  logic            cm_empty,
  input  logic            hit_valid,
  output logic            hit_ready,
  input  logic [2:0]      hit_tblk,
  input  logic [6:0]      hit_strip,
  input  logic [8:0]      hit_height,
  input  logic            hit_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_data,
  output logic            out_hdr,
  output logic            out_trl,
  output logic            out_den,
  output logic            out_half
);
  logic [CNT_W-1:0] cnt [N_IN];
  logic [15:0]      crc;
  logic             crc_init;
  logic             crc_upd;

  fmt_evtcnt #(.N_IN(N_IN)) u_cnt (
    .clk(clk), .rst(rst), .seen(chip_hdr_seen), .cnt(cnt)
  );

  fmt_crc16 u_crc (
    .clk(clk), .rst(rst), .init(crc_init), .upd(crc_upd),
    .word(out_data), .crc(crc)
  );

  fmt_seq #(.N_IN(N_IN)) u_seq (
    .clk(clk), .rst(rst), .cfg_ihdr_en(cfg_ihdr_en), .cnt(cnt),
    .crc(crc), .crc_init(crc_init), .crc_upd(crc_upd),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_trig_type(evt_trig_type), .evt_data_type(evt_data_type),
    .evt_clk_phase(evt_clk_phase), .evt_module(evt_module),
    .evt_number(evt_number),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_corr1(cm_corr1),
    .cm_corr2(cm_corr2), .cm_empty(cm_empty),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_tblk(hit_tblk),
    .hit_strip(hit_strip), .hit_height(hit_height), .hit_last(hit_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_hdr(out_hdr), .out_trl(out_trl), .out_den(out_den),
    .out_half(out_half)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && evt_ready); // R11
endmodule

// File: tb/evt_block_fmt_bench.sv
`timescale 1ns/1ps
module evt_block_fmt_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cfg_ihdr_en = 1'b1;
  logic [N-1:0]  chip_hdr_seen = '0;
  logic          evt_valid = 1'b0;
  logic          evt_ready;
  logic [3:0]    evt_trig_type = '0;
  logic [2:0]    evt_data_type = '0;
  logic [4:0]    evt_clk_phase = '0;
  logic [4:0]    evt_module = '0;
  logic [7:0]    evt_number = '0;
  logic          cm_valid = 1'b0, cm_ready, cm_empty = 1'b0;
  logic [8:0]    cm_corr1 = '0;
  logic [6:0]    cm_corr2 = '0;
  logic          hit_valid = 1'b0, hit_ready, hit_last = 1'b0;
  logic [2:0]    hit_tblk = '0;
  logic [6:0]    hit_strip = '0;
  logic [8:0]    hit_height = '0;
  logic          out_valid, out_ready = 1'b1;
  logic [31:0]   out_data;
  logic          out_hdr, out_trl, out_den, out_half;

  evt_block_fmt u_evt_block_fmt (.*);

  int n_chk = 0, n_fail = 0;
  int nh [N];
  logic [6:0] mcnt [N];
  logic [31:0] exp_d [128];
  logic [3:0]  exp_s [128];
  logic [31:0] cap_d [128];
  logic [3:0]  cap_s [128];
  int nexp, ncap;
  bit rnd_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bcrc(logic [15:0] c, logic [31:0] w);
    logic [15:0] r = c;
    for (int i = 0; i < 32; i++) begin
      logic b = r[15] ^ w[31 - i];
      r = (r << 1) ^ (b ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [8:0] f_c1(int i, int e); return 9'((i * 29 + e * 5) % 512); endfunction
  function automatic logic [6:0] f_c2(int i, int e); return 7'((i * 11 + e) % 128); endfunction
  function automatic logic [2:0] f_tb(int j); return 3'(1 + (j % 6)); endfunction
  function automatic logic [6:0] f_st(int i, int j); return 7'((i * 7 + j * 3) % 128); endfunction
  function automatic logic [8:0] f_ph(int i, int j, int e); return 9'((i * 37 + j * 101 + e * 13) % 512); endfunction

  always @(negedge clk)
    if (!rst && out_valid && out_ready && ncap < 128) begin
      cap_d[ncap] = out_data;
      cap_s[ncap] = {out_hdr, out_trl, out_den, out_half};
      ncap++;
    end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic pulse(logic [N-1:0] mask);
    @(posedge clk); #1 chip_hdr_seen = mask;
    @(posedge clk); #1 chip_hdr_seen = '0;
    for (int i = 0; i < N; i++) if (mask[i]) mcnt[i] = mcnt[i] + 1'b1;
  endtask

  task automatic feed_cm(int e);
    for (int i = 0; i < N; i++) begin
      cm_valid = 1'b1; cm_corr1 = f_c1(i, e); cm_corr2 = f_c2(i, e);
      cm_empty = (nh[i] == 0);
      do @(negedge clk); while (!cm_ready);
      @(posedge clk); #1;
    end
    cm_valid = 1'b0;
  endtask

  task automatic feed_hit(int e);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < nh[i]; j++) begin
        hit_valid = 1'b1; hit_tblk = f_tb(j); hit_strip = f_st(i, j);
        hit_height = f_ph(i, j, e); hit_last = (j == nh[i] - 1);
        do @(negedge clk); while (!hit_ready);
        @(posedge clk); #1;
      end
    hit_valid = 1'b0;
  endtask

  task automatic run_event(int e, bit en, logic [7:0] sys, logic [3:0] tt,
                           logic [2:0] dt, logic [4:0] cp, logic [4:0] md);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] errs = '0;
    nexp = 0;
    exp_d[nexp] = {1'b0, tt, 1'b0, dt, 2'b0, cp, 2'b0, md, 1'b0, sys};
    exp_s[nexp++] = 4'b1000;
    for (int i = 0; i < N; i++) begin
      logic hf = (i >= N / 2);
      errs[i] = (mcnt[i] != sys[6:0]);
      if (en) begin
        exp_d[nexp] = {1'b1, 1'b0, mcnt[i], 3'b0, 4'(i), f_c2(i, e), f_c1(i, e)};
        exp_s[nexp++] = {3'b001, hf};
      end
      for (int j = 0; j < nh[i]; j++) begin
        exp_d[nexp] = {9'b0, f_tb(j), 4'(i), f_st(i, j), f_ph(i, j, e)};
        exp_s[nexp++] = {3'b001, hf};
      end
    end
    for (int k = 0; k < nexp; k++) c = bcrc(c, exp_d[k]);
    exp_d[nexp] = {c, errs};
    exp_s[nexp++] = 4'b0100;

    ncap = 0;
    @(posedge clk); #1;
    cfg_ihdr_en = en; evt_trig_type = tt; evt_data_type = dt;
    evt_clk_phase = cp; evt_module = md; evt_number = sys;
    fork
      begin
        evt_valid = 1'b1;
        do @(negedge clk); while (!evt_ready);
        @(posedge clk); #1 evt_valid = 1'b0;
      end
      feed_cm(e);
      feed_hit(e);
    join
    for (int t = 0; t < 3000 && ncap < nexp; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check($sformatf("R4 word count ev%0d", e), ncap, nexp);
    for (int k = 0; k < nexp && k < ncap; k++) begin
      string rq = (k == 0) ? "R1" : (k == nexp - 1) ? "R6/R7" :
                  (exp_d[k][31] ? "R2/R5" : "R3");
      check($sformatf("%s word %0d ev%0d", rq, k, e), cap_d[k], exp_d[k]);
      check($sformatf("R8 flags word %0d ev%0d", k, e), 32'(cap_s[k]), 32'(exp_s[k]));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mcnt[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R11 out_valid after reset", 32'(out_valid), 0);
    check("R11 evt_ready after reset", 32'(evt_ready), 1);
    check("R11 cm_ready idle", 32'(cm_ready), 0);

    // ev0: all inputs empty, headers on, no stalls
    pulse('1);
    for (int i = 0; i < N; i++) nh[i] = 0;
    run_event(0, 1, 8'd1, 4'hA, 3'd5, 5'd17, 5'd9);

    // ev1: varied hit counts, random back-pressure (R9)
    rnd_ready = 1;
    pulse('1);
    for (int i = 0; i < N; i++) nh[i] = i % 4;
    run_event(1, 1, 8'd2, 4'h3, 3'd1, 5'd31, 5'd22);

    // ev2: input headers off (R5), input 5 missed a chip header (R7)
    pulse(~(16'h1 << 5));
    for (int i = 0; i < N; i++) nh[i] = (i + 1) % 3;
    run_event(2, 0, 8'd3, 4'hF, 3'd7, 5'd0, 5'd31);

    // ev3: input 3 counter wraps after 128 extra pulses (R10)
    pulse('1);
    for (int k = 0; k < 128; k++) pulse(16'h1 << 3);
    for (int i = 0; i < N; i++) nh[i] = (i == 15) ? 3 : 0;
    run_event(3, 1, 8'd4, 4'h1, 3'd2, 5'd8, 5'd1);

    // ev4: input 5 resynchronised, error bits clear (R7)
    pulse('1);
    pulse(16'h1 << 5);
    for (int i = 0; i < N; i++) nh[i] = 2;
    run_event(4, 1, 8'd5, 4'h7, 3'd4, 5'd12, 5'd16);

    // ev5: headers off and all empty: header then trailer only
    rnd_ready = 0;
    pulse('1);
    for (int i = 0; i < N; i++) nh[i] = 0;
    run_event(5, 0, 8'd6, 4'h0, 3'd0, 5'd3, 5'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule